// File: doc/BRIEF.md
# Ternary Search Memory with Split-Flag Write

This block is a synthesizable ternary content-addressable memory. It holds `WORDS` entries of `BITS` ternary symbols. Each symbol is kept as two flags, a positive flag and a negative flag. A 0 is stored as (0,1), a 1 as (1,0), and a don't-care as (0,0). No legal stored value has both flags set.

A write names one entry and supplies a value and care mask; a care bit of 0 makes that symbol a wildcard. The write always takes two clock cycles, whatever the entry held before. The first cycle updates only the positive flags and the second updates only the negative flags, so the entry passes through an intermediate pair state.

A search supplies a key with its own care mask. It spends one cycle with every match line precharged to "match" and one cycle evaluating. It then reports the per-entry match lines, a hit flag, a multiple-hit flag and the lowest matching index. Both ports use a request/ready handshake. A write wins over a search offered in the same cycle. A search is held off while a write is in its second step.

Top module: `tcam_2step`

## Requirements
- R1: A write with care bit 0 stores that symbol as a wildcard, and a stored wildcard matches a key bit of either 0 or 1; outside a write no stored symbol has both flags set.
- R2: A write is accepted on a clock edge with `wr_req` and `wr_ready` high. `wr_ready` is low for exactly the following cycle and high again after the next edge; the positive flags change at the first edge and the negative flags only at the second.
- R3: A key symbol with care bit 0 matches any stored symbol.
- R4: A stored definite symbol matches only an equal definite key symbol (value bit 1 means 1, value bit 0 means 0).
- R5: An entry matches only when none of its symbols mismatch; a single mismatching symbol clears that entry's bit in `match_vec`.
- R6: In the cycle after a search is accepted, `match_vec` is all ones and `srch_done` is low. After the next edge, `match_vec` holds the result and `srch_done` is high for one cycle.
- R7: Accepting a write forces `match_vec` to all zeros and clears `hit`, `multi_hit` and `hit_addr`.
- R8: With a result, `hit` is 1 when any entry matches, `multi_hit` is 1 when two or more match, and `hit_addr` is the lowest matching index. With no match, all three are 0.
- R9: `srch_ready` is low while `wr_req` is high or a write is in progress; a search waiting in that time is accepted only once the write completes.
- R10: Reset leaves every stored symbol a wildcard and every output register at zero, so the first search matches every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | ADDR_W | Entry to write |
| wr_val | input | BITS | Write value bits |
| wr_care | input | BITS | Write care mask, 0 = wildcard |
| srch_req | input | 1 | Search request |
| srch_ready | output | 1 | Search can be accepted this cycle |
| srch_val | input | BITS | Key value bits |
| srch_care | input | BITS | Key care mask, 0 = wildcard |
| match_vec | output | WORDS | Match lines, one per entry |
| hit | output | 1 | At least one entry matched |
| multi_hit | output | 1 | Two or more entries matched |
| hit_addr | output | ADDR_W | Lowest matching entry index |
| srch_done | output | 1 | One-cycle pulse when a result is present |

## Verification
The assertions assume that `wr_addr` names an existing entry whenever a write is accepted. They also assume requests change only between edges, never at the edge itself. The bench drives every input shortly after the falling edge and only uses entry indices below `WORDS`. It holds a request until it sees ready before the rising edge, so no accepted write or search carries an out-of-range index or a value that shifts during sampling.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WR2  = 2'd1,
    PH_EVAL = 2'd2
  } phase_e;

  // Mismatch of one stored flag pair against one key symbol.
  function automatic logic sym_miss(logic pos, logic neg, logic kval, logic kcare);
    return kcare & ((kval & neg) | (~kval & pos));
  endfunction

endpackage

// File: rtl/tcam_row.sv
module tcam_row #(
  parameter int BITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            step1_en,
  input  logic            step2_en,
  input  logic [BITS-1:0] pos_in,
  input  logic [BITS-1:0] neg_in,
  input  logic [BITS-1:0] key_val,
  input  logic [BITS-1:0] key_care,
  output logic            row_hit
);
  import tcam_pkg::*;

  logic [BITS-1:0] pos_q;
  logic [BITS-1:0] neg_q;
  logic [BITS-1:0] miss_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      neg_q <= '0;
    end else begin
      if (step1_en) pos_q <= pos_in;
      if (step2_en) neg_q <= neg_in;
    end
  end

  generate
    for (genvar b = 0; b < BITS; b++) begin : g_sym
      assign miss_v[b] = sym_miss(pos_q[b], neg_q[b], key_val[b], key_care[b]);
    end
  endgenerate

  assign row_hit = ~|miss_v;

  AST_STEP1_KEEPS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    step1_en |=> $stable(neg_q)); // R2
  AST_STEP2_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    step2_en |=> $stable(pos_q)); // R2
  AST_NO_DOUBLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> ((pos_q & neg_q) == '0)); // R1

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int WORDS  = 4,
  parameter int ADDR_W = 2
) (
  input  logic [WORDS-1:0]  lines,
  output logic              any,
  output logic              multi,
  output logic [ADDR_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (lines[i]) idx = ADDR_W'(i);
    end
  end

  assign any   = |lines;
  assign multi = (lines & (lines - WORDS'(1))) != '0;

endmodule

// File: rtl/tcam_ctrl.sv
module tcam_ctrl #(
  parameter int BITS   = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              srch_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BITS-1:0]   wr_neg,
  input  logic [BITS-1:0]   srch_val,
  input  logic [BITS-1:0]   srch_care,
  output logic              wr_ready,
  output logic              srch_ready,
  output logic              wr_fire,
  output logic              srch_fire,
  output logic              step2,
  output logic              eval,
  output logic              idle,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [BITS-1:0]   lat_neg,
  output logic [BITS-1:0]   key_val,
  output logic [BITS-1:0]   key_care
);
  import tcam_pkg::*;

  phase_e ph_q;

  assign idle       = (ph_q == PH_IDLE);
  assign step2      = (ph_q == PH_WR2);
  assign eval       = (ph_q == PH_EVAL);
  assign wr_ready   = idle;
  assign srch_ready = idle & ~wr_req;
  assign wr_fire    = idle & wr_req;
  assign srch_fire  = idle & srch_req & ~wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      lat_addr <= '0;
      lat_neg  <= '0;
      key_val  <= '0;
      key_care <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (wr_fire) begin
            ph_q     <= PH_WR2;
            lat_addr <= wr_addr;
            lat_neg  <= wr_neg;
          end else if (srch_fire) begin
            ph_q     <= PH_EVAL;
            key_val  <= srch_val;
            key_care <= srch_care;
          end
        end
        PH_WR2:  ph_q <= PH_IDLE;
        PH_EVAL: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_WRITE_SECOND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (step2 && !wr_ready)); // R2
  AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    step2 |=> wr_ready); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !srch_fire); // R9
  AST_SEARCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    step2 |-> !srch_ready); // R9

endmodule

// File: rtl/tcam_2step.sv
module tcam_2step #(
  parameter int WORDS  = 4,
  parameter int BITS   = 4,
  parameter int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BITS-1:0]   wr_val,
  input  logic [BITS-1:0]   wr_care,
  input  logic              srch_req,
  output logic              srch_ready,
  input  logic [BITS-1:0]   srch_val,
  input  logic [BITS-1:0]   srch_care,
  output logic [WORDS-1:0]  match_vec,
  output logic              hit,
  output logic              multi_hit,
  output logic [ADDR_W-1:0] hit_addr,
  output logic              srch_done
);

  logic              wr_fire, srch_fire, step2, eval, idle;
  logic [ADDR_W-1:0] lat_addr;
  logic [BITS-1:0]   lat_neg, key_val, key_care;
  logic [BITS-1:0]   new_pos, new_neg;
  logic [WORDS-1:0]  row_hits;
  logic              enc_any, enc_multi;
  logic [ADDR_W-1:0] enc_idx;

  assign new_pos = wr_val & wr_care;
  assign new_neg = ~wr_val & wr_care;

  tcam_ctrl #(.BITS(BITS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .srch_req(srch_req),
    .wr_addr(wr_addr), .wr_neg(new_neg), .srch_val(srch_val), .srch_care(srch_care),
    .wr_ready(wr_ready), .srch_ready(srch_ready), .wr_fire(wr_fire),
    .srch_fire(srch_fire), .step2(step2), .eval(eval), .idle(idle),
    .lat_addr(lat_addr), .lat_neg(lat_neg), .key_val(key_val), .key_care(key_care)
  );

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_row
      logic s1_en, s2_en;
      assign s1_en = wr_fire && (wr_addr == ADDR_W'(w));
      assign s2_en = step2 && (lat_addr == ADDR_W'(w));
      tcam_row #(.BITS(BITS)) row_i (
        .clk(clk), .rst_n(rst_n), .idle(idle), .step1_en(s1_en), .step2_en(s2_en),
        .pos_in(new_pos), .neg_in(lat_neg), .key_val(key_val), .key_care(key_care),
        .row_hit(row_hits[w])
      );
    end
  endgenerate

  tcam_prio_enc #(.WORDS(WORDS), .ADDR_W(ADDR_W)) enc_i (
    .lines(row_hits), .any(enc_any), .multi(enc_multi), .idx(enc_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_vec <= '0;
      hit       <= 1'b0;
      multi_hit <= 1'b0;
      hit_addr  <= '0;
      srch_done <= 1'b0;
    end else if (wr_fire) begin
      match_vec <= '0;
      hit       <= 1'b0;
      multi_hit <= 1'b0;
      hit_addr  <= '0;
      srch_done <= 1'b0;
    end else if (srch_fire) begin
      match_vec <= '1;
      hit       <= 1'b0;
      multi_hit <= 1'b0;
      hit_addr  <= '0;
      srch_done <= 1'b0;
    end else if (eval) begin
      match_vec <= row_hits;
      hit       <= enc_any;
      multi_hit <= enc_multi;
      hit_addr  <= enc_idx;
      srch_done <= 1'b1;
    end else begin
      srch_done <= 1'b0;
    end
  end

  AST_WRITE_DROPS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (match_vec == '0 && !hit)); // R7
  AST_PRECHARGE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    srch_fire |=> (&match_vec && !srch_done)); // R6
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> $past(srch_fire, 2)); // R6
  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (hit == (match_vec != '0))); // R8
  AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (multi_hit == ($countones(match_vec) > 1))); // R8
  AST_ADDR_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && hit) |-> (match_vec[hit_addr] && ((match_vec & ((WORDS'(1) << hit_addr) - WORDS'(1))) == '0))); // R8

endmodule

// File: tb/tcam_2step_tb_top.sv
module tcam_2step_tb_top;
  localparam int W  = 4;
  localparam int B  = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, srch_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [B-1:0] wr_val = '0, wr_care = '0, srch_val = '0, srch_care = '0;
  logic wr_ready, srch_ready, hit, multi_hit, srch_done;
  logic [W-1:0] match_vec;
  logic [AW-1:0] hit_addr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tcam_2step #(.WORDS(W), .BITS(B), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_val(wr_val), .wr_care(wr_care), .srch_req(srch_req),
    .srch_ready(srch_ready), .srch_val(srch_val), .srch_care(srch_care),
    .match_vec(match_vec), .hit(hit), .multi_hit(multi_hit), .hit_addr(hit_addr),
    .srch_done(srch_done)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: symbols 0, 1, 2 (=wildcard), phase counter.
  int ph = 0;
  int mem [W][B];
  int e_mv = 0, e_hit = 0, e_multi = 0, e_addr = 0, e_done = 0;
  int kv [B];
  int kc [B];

  initial begin
    for (int w = 0; w < W; w++) for (int b = 0; b < B; b++) mem[w][b] = 2;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; e_mv = 0; e_hit = 0; e_multi = 0; e_addr = 0; e_done = 0;
      for (int w = 0; w < W; w++) for (int b = 0; b < B; b++) mem[w][b] = 2;
    end else if (ph == 0) begin
      e_done = 0;
      if (wr_req) begin
        for (int b = 0; b < B; b++) mem[int'(wr_addr)][b] = wr_care[b] ? int'(wr_val[b]) : 2;
        e_mv = 0; e_hit = 0; e_multi = 0; e_addr = 0; ph = 1;
      end else if (srch_req) begin
        for (int b = 0; b < B; b++) begin kv[b] = int'(srch_val[b]); kc[b] = int'(srch_care[b]); end
        e_mv = (1 << W) - 1; e_hit = 0; e_multi = 0; e_addr = 0; ph = 2;
      end
    end else if (ph == 1) begin
      ph = 0;
    end else begin
      int cnt;
      cnt = 0; e_mv = 0; e_addr = 0;
      for (int w = W - 1; w >= 0; w--) begin
        bit ok;
        ok = 1;
        for (int b = 0; b < B; b++)
          if (kc[b] == 1 && mem[w][b] != 2 && mem[w][b] != kv[b]) ok = 0;
        if (ok) begin e_mv = e_mv | (1 << w); cnt++; e_addr = w; end
      end
      e_hit = (cnt > 0); e_multi = (cnt > 1); e_done = 1; ph = 0;
    end
  end

  always @(negedge clk) begin
    cmp("R5", "match_vec", int'(match_vec), e_mv);
    cmp("R8", "hit", int'(hit), e_hit);
    cmp("R8", "multi_hit", int'(multi_hit), e_multi);
    cmp("R8", "hit_addr", int'(hit_addr), e_addr);
    cmp("R6", "srch_done", int'(srch_done), e_done);
    cmp("R2", "wr_ready", int'(wr_ready), int'(ph == 0));
    cmp("R9", "srch_ready", int'(srch_ready), int'(ph == 0 && !wr_req));
  end

  task automatic do_write(input int a, input logic [B-1:0] v, input logic [B-1:0] c);
    bit acc;
    @(negedge clk); #1;
    wr_req = 1; wr_addr = AW'(a); wr_val = v; wr_care = c;
    while (1) begin
      #2; acc = wr_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    wr_req = 0;
    cmp("R2", "wr_ready in step 2", int'(wr_ready), 0);
    cmp("R7", "match_vec after write", int'(match_vec), 0);
    @(posedge clk); @(negedge clk); #1;
    cmp("R2", "wr_ready after write", int'(wr_ready), 1);
  endtask

  task automatic do_search(input logic [B-1:0] v, input logic [B-1:0] c);
    bit acc;
    @(negedge clk); #1;
    srch_req = 1; srch_val = v; srch_care = c;
    while (1) begin
      #2; acc = srch_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    srch_req = 0;
    cmp("R6", "precharge lines", int'(match_vec), (1 << W) - 1);
    cmp("R6", "done during precharge", int'(srch_done), 0);
    @(posedge clk); @(negedge clk); #1;
    cmp("R6", "done after evaluate", int'(srch_done), 1);
  endtask

  task automatic expect_res(input string tag, input int mv, input int h, input int m, input int a);
    cmp(tag, "match_vec", int'(match_vec), mv);
    cmp(tag, "hit", int'(hit), h);
    cmp(tag, "multi_hit", int'(multi_hit), m);
    cmp(tag, "hit_addr", int'(hit_addr), a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    expect_res("R10", 0, 0, 0, 0);
    rst_n = 1;
    // R10: all wildcards after reset
    do_search(4'hF, 4'hF);
    expect_res("R10", 4'b1111, 1, 1, 0);
    // Load: w0 = 1X10, w1 = 0X01, w2 = 1111, w3 = 0000 (bit 3 leftmost)
    do_write(0, 4'b1010, 4'b1011);
    do_write(1, 4'b0001, 4'b1011);
    do_write(2, 4'b1111, 4'b1111);
    do_write(3, 4'b0000, 4'b1111);
    // R4 R5: key 11X0 matches only w0
    do_search(4'b1100, 4'b1101);
    expect_res("R4", 4'b0001, 1, 0, 0);
    // R4 R5: key 01X1 matches only w1
    do_search(4'b0101, 4'b1101);
    expect_res("R5", 4'b0010, 1, 0, 1);
    // R3: all-wildcard key
    do_search(4'b0000, 4'b0000);
    expect_res("R3", 4'b1111, 1, 1, 0);
    // R8: single match at index 2
    do_search(4'b1111, 4'b1111);
    expect_res("R8", 4'b0100, 1, 0, 2);
    // R8: no match
    do_search(4'b0110, 4'b1111);
    expect_res("R8", 0, 0, 0, 0);
    // R1: wildcard entry matches both polarities
    do_write(3, 4'b1111, 4'b0000);
    do_search(4'b1010, 4'b1111);
    expect_res("R1", 4'b1001, 1, 1, 0);
    do_search(4'b0101, 4'b1111);
    expect_res("R1", 4'b1010, 1, 1, 1);
    // R2: overwrite 1111 -> 0000 regardless of old content
    do_write(2, 4'b0000, 4'b1111);
    do_search(4'b0000, 4'b1111);
    expect_res("R2", 4'b1100, 1, 1, 2);
    // R9: simultaneous requests, write wins, search waits
    @(negedge clk); #1;
    wr_req = 1; wr_addr = 2'd0; wr_val = 4'b0110; wr_care = 4'b1111;
    srch_req = 1; srch_val = 4'b0110; srch_care = 4'b1111;
    #2;
    cmp("R9", "srch_ready with write pending", int'(srch_ready), 0);
    @(posedge clk); @(negedge clk); #1;
    wr_req = 0;
    cmp("R9", "srch_ready during step 2", int'(srch_ready), 0);
    @(posedge clk); @(negedge clk); #1;
    cmp("R9", "srch_ready after write", int'(srch_ready), 1);
    @(posedge clk); @(negedge clk); #1;
    srch_req = 0;
    cmp("R6", "precharge after stall", int'(match_vec), 4'b1111);
    @(posedge clk); @(negedge clk); #1;
    expect_res("R9", 4'b1001, 1, 1, 0);
    // R7: write after result clears flags
    do_write(1, 4'b1110, 4'b1110);
    expect_res("R7", 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule